// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block collects the interrupt requests of one UART channel and reduces them to a single identification byte. The byte names the most urgent enabled source and shows whether anything is pending at all. The host reads this byte to decide which service routine to run. An active-low interrupt line follows the pending state, so the host is only interrupted when there is work.

There are eight sources:

- Three level requests come from the receiver: a line status error, a receive time-out and receive data available.
- Transmit-holding-empty is a latched event.
- Four further latched events cover the rest: a modem status change, an input pin change, an Xoff or special character match, and a flow-control line going inactive.

Each latched event stays set until the register that owns it is read. A flow-control event is a low-to-high transition on the CTS or RTS input. Modem and pin-change details are not in the identification byte. The host reads the modem-status and IO-state registers for those, and those reads clear the matching flags. The identification byte is registered and holds its value while a read strobe is active.

Top module: `uart_irq_ident`

## Requirements
- R1: Bit 0 of `ident` is 0 when at least one enabled source is pending and 1 otherwise. With nothing pending, bits 5:0 read 6'h01.
- R2: Bits 7 and 6 of `ident` both copy `fifo_en`.
- R3: Bits 5:0 of `ident` name the winning source with these values:
  - 6'h06: line status error.
  - 6'h0C: receive time-out.
  - 6'h04: receive data available.
  - 6'h02: transmit holding empty.
  - 6'h00: modem change.
  - 6'h30: pin change.
  - 6'h10: Xoff/special character.
  - 6'h20: flow-control inactive.

  This list runs from highest to lowest priority.
- R4: A line status error outranks every other source. A receive time-out outranks receive data available.
- R5: A source whose enable input is 0 neither sets the code nor clears bit 0. Its latched flag is kept and is reported once the enable is set.
- R6: The transmit-empty flag is cleared in two ways: a `rd_ident` strobe while `ident` reports 6'h02, or a `thr_wr` strobe. A read that reports another source leaves the flag set.
- R7: The modem flag is cleared only by `rd_msr`. The pin-change flag is cleared only by `rd_iostate`. A `rd_ident` strobe clears neither flag.
- R8: The Xoff flag and the flow-control flag are each cleared by a `rd_ident` strobe while `ident` reports that flag's own code.
- R9: A low-to-high change on `cts_n` or `rts_n` sets the flow-control flag. A high-to-low change does not set it.
- R10: `ident` is registered: a change of a level source shows on `ident` after one rising clock edge. `irq_n` equals bit 0 of `ident`.
- R11: While `rd_ident` is high, `ident` holds its value. The value updates on the first edge after `rd_ident` falls.
- R12: When an event strobe and the clear for the same flag arrive in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO enable control bit, mirrored into ident[7:6] |
| en_rls | input | 1 | Enable for the line status source |
| en_rx | input | 1 | Enable for the receive time-out and receive data sources |
| en_thr | input | 1 | Enable for the transmit-empty source |
| en_modem | input | 1 | Enable for the modem source |
| en_pin | input | 1 | Enable for the pin-change source |
| en_xoff | input | 1 | Enable for the Xoff/special character source |
| en_flow | input | 1 | Enable for the flow-control source |
| lsr_err | input | 1 | Line status error request (level) |
| rx_tmo | input | 1 | Receive time-out request (level) |
| rx_avail | input | 1 | Receive data available request (level) |
| thr_set | input | 1 | Transmit holding register became empty (pulse) |
| thr_wr | input | 1 | Host write to the transmit holding register (pulse) |
| modem_chg | input | 1 | Modem status change event (pulse) |
| pin_chg | input | 1 | Input pin change event (pulse) |
| xoff_det | input | 1 | Xoff or special character received (pulse) |
| cts_n | input | 1 | CTS line, active low |
| rts_n | input | 1 | RTS line, active low |
| rd_ident | input | 1 | Host read of the identification byte |
| rd_msr | input | 1 | Host read of the modem-status register |
| rd_iostate | input | 1 | Host read of the IO-state register |
| ident | output | 8 | Registered identification byte |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The hardest state to reach from the ports is a clear that must be selective. This covers two cases: a read that returns one code while a lower latched flag waits underneath, and an event and its clear landing in the same clock. The bench gets there by pulsing a latched event while a higher level source is held. It then reads the byte, drops the level source, and checks that the latched code appears. For the same-cycle case it drives an event strobe and its owning read strobe on one edge and checks that the flag survives. Flow-control edges are produced by toggling the active-low lines in both directions, so that only the rising edge is seen to raise the code.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_en,
  input  logic       en_rls,
  input  logic       en_rx,
  input  logic       en_thr,
  input  logic       en_modem,
  input  logic       en_pin,
  input  logic       en_xoff,
  input  logic       en_flow,
  input  logic       lsr_err,
  input  logic       rx_tmo,
  input  logic       rx_avail,
  input  logic       thr_set,
  input  logic       thr_wr,
  input  logic       modem_chg,
  input  logic       pin_chg,
  input  logic       xoff_det,
  input  logic       cts_n,
  input  logic       rts_n,
  input  logic       rd_ident,
  input  logic       rd_msr,
  input  logic       rd_iostate,
  output logic [7:0] ident,
  output logic       irq_n
);

  localparam logic [5:0] C_RLS  = 6'h06;
  localparam logic [5:0] C_TMO  = 6'h0C;
  localparam logic [5:0] C_RX   = 6'h04;
  localparam logic [5:0] C_THR  = 6'h02;
  localparam logic [5:0] C_MDM  = 6'h00;
  localparam logic [5:0] C_PIN  = 6'h30;
  localparam logic [5:0] C_XOFF = 6'h10;
  localparam logic [5:0] C_FLOW = 6'h20;
  localparam logic [5:0] C_NONE = 6'h01;

  logic       thr_q, mdm_q, pin_q, xoff_q, flow_q;
  logic       cts_q, rts_q;
  logic       flow_rise;
  logic       rd_thr, rd_xoff, rd_flow;
  logic [5:0] code;
  logic [7:0] ident_q;

  assign flow_rise = (cts_n & ~cts_q) | (rts_n & ~rts_q);
  assign rd_thr    = rd_ident & (ident_q[5:0] == C_THR);
  assign rd_xoff   = rd_ident & (ident_q[5:0] == C_XOFF);
  assign rd_flow   = rd_ident & (ident_q[5:0] == C_FLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= 1'b0;
      mdm_q  <= 1'b0;
      pin_q  <= 1'b0;
      xoff_q <= 1'b0;
      flow_q <= 1'b0;
      cts_q  <= 1'b1;
      rts_q  <= 1'b1;
    end else begin
      thr_q  <= thr_set   | (thr_q  & ~thr_wr & ~rd_thr);
      mdm_q  <= modem_chg | (mdm_q  & ~rd_msr);
      pin_q  <= pin_chg   | (pin_q  & ~rd_iostate);
      xoff_q <= xoff_det  | (xoff_q & ~rd_xoff);
      flow_q <= flow_rise | (flow_q & ~rd_flow);
      cts_q  <= cts_n;
      rts_q  <= rts_n;
    end
  end

  always_comb begin
    if      (en_rls   && lsr_err)  code = C_RLS;
    else if (en_rx    && rx_tmo)   code = C_TMO;
    else if (en_rx    && rx_avail) code = C_RX;
    else if (en_thr   && thr_q)    code = C_THR;
    else if (en_modem && mdm_q)    code = C_MDM;
    else if (en_pin   && pin_q)    code = C_PIN;
    else if (en_xoff  && xoff_q)   code = C_XOFF;
    else if (en_flow  && flow_q)   code = C_FLOW;
    else                           code = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ident_q <= {2'b00, C_NONE};
    else if (!rd_ident) ident_q <= {fifo_en, fifo_en, code};
  end

  assign ident = ident_q;
  assign irq_n = ident_q[0];

  assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ident[0] |-> ident[5:0] == C_NONE);

  assert_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(rd_ident)) |-> ident[7:6] == {2{$past(fifo_en)}});

  assert_rls_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rls && lsr_err && !rd_ident) |=> ident[5:0] == C_RLS);

  assert_hold_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ident |=> $stable(ident));

  assert_modem_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && !modem_chg) |=> !mdm_q);

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    thr_set |=> thr_q);

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0;
  logic en_rls = 1'b0, en_rx = 1'b0, en_thr = 1'b0, en_modem = 1'b0;
  logic en_pin = 1'b0, en_xoff = 1'b0, en_flow = 1'b0;
  logic lsr_err = 1'b0, rx_tmo = 1'b0, rx_avail = 1'b0;
  logic thr_set = 1'b0, thr_wr = 1'b0, modem_chg = 1'b0, pin_chg = 1'b0, xoff_det = 1'b0;
  logic cts_n = 1'b1, rts_n = 1'b1;
  logic rd_ident = 1'b0, rd_msr = 1'b0, rd_iostate = 1'b0;
  logic [7:0] ident;
  logic irq_n;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  uart_irq_ident i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .en_rls(en_rls), .en_rx(en_rx), .en_thr(en_thr), .en_modem(en_modem),
    .en_pin(en_pin), .en_xoff(en_xoff), .en_flow(en_flow),
    .lsr_err(lsr_err), .rx_tmo(rx_tmo), .rx_avail(rx_avail),
    .thr_set(thr_set), .thr_wr(thr_wr), .modem_chg(modem_chg),
    .pin_chg(pin_chg), .xoff_det(xoff_det), .cts_n(cts_n), .rts_n(rts_n),
    .rd_ident(rd_ident), .rd_msr(rd_msr), .rd_iostate(rd_iostate),
    .ident(ident), .irq_n(irq_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_id();
    rd_ident = 1'b1; tick(1); rd_ident = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1 idle byte", ident, 8'h01);
    chk("R10 irq_n idle", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_mirror();
    fifo_en = 1'b1; tick(2);
    chk("R2 mirror set", ident, 8'hC1);
    fifo_en = 1'b0; tick(2);
    chk("R2 mirror clear", ident, 8'h01);
  endtask

  task automatic t_receive();
    lsr_err = 1'b1;
    chk("R10 no change before edge", ident, 8'h01);
    tick(1);
    chk("R10 one edge to line status", ident, 8'h06);
    chk("R10 irq_n low", {7'b0, irq_n}, 8'h00);
    rx_tmo = 1'b1; rx_avail = 1'b1; tick(2);
    chk("R4 line status over receive", ident, 8'h06);
    lsr_err = 1'b0; tick(2);
    chk("R4 timeout over data", ident, 8'h0C);
    rx_tmo = 1'b0; tick(2);
    chk("R3 receive data", ident, 8'h04);
    rx_avail = 1'b0; tick(2);
    chk("R1 back to idle", ident, 8'h01);
  endtask

  task automatic t_thr();
    thr_set = 1'b1; tick(1); thr_set = 1'b0; tick(2);
    chk("R3 transmit empty", ident, 8'h02);
    rd_id();
    chk("R6 read clears transmit empty", ident, 8'h01);
    thr_set = 1'b1; tick(1); thr_set = 1'b0; tick(2);
    thr_wr = 1'b1; tick(1); thr_wr = 1'b0; tick(2);
    chk("R6 write clears transmit empty", ident, 8'h01);
    lsr_err = 1'b1; thr_set = 1'b1; tick(1); thr_set = 1'b0; tick(2);
    chk("R3 line status over transmit", ident, 8'h06);
    rd_id();
    lsr_err = 1'b0; tick(2);
    chk("R6 other read keeps transmit empty", ident, 8'h02);
    thr_wr = 1'b1; tick(1); thr_wr = 1'b0; tick(2);
    chk("R6 cleanup", ident, 8'h01);
  endtask

  task automatic t_modem_pin();
    modem_chg = 1'b1; tick(1); modem_chg = 1'b0; tick(2);
    chk("R3 modem code", ident, 8'h00);
    chk("R1 modem irq_n", {7'b0, irq_n}, 8'h00);
    rd_id();
    chk("R7 ident read keeps modem", ident, 8'h00);
    rd_msr = 1'b1; tick(1); rd_msr = 1'b0; tick(2);
    chk("R7 msr read clears modem", ident, 8'h01);
    pin_chg = 1'b1; tick(1); pin_chg = 1'b0; tick(2);
    chk("R3 pin code", ident, 8'h30);
    rd_id();
    chk("R7 ident read keeps pin", ident, 8'h30);
    rd_msr = 1'b1; tick(1); rd_msr = 1'b0; tick(2);
    chk("R7 msr read keeps pin", ident, 8'h30);
    modem_chg = 1'b1; tick(1); modem_chg = 1'b0; tick(2);
    chk("R3 modem over pin", ident, 8'h00);
    rd_msr = 1'b1; tick(1); rd_msr = 1'b0; tick(2);
    chk("R3 pin after modem cleared", ident, 8'h30);
    rd_iostate = 1'b1; tick(1); rd_iostate = 1'b0; tick(2);
    chk("R7 iostate read clears pin", ident, 8'h01);
  endtask

  task automatic t_xoff_flow();
    xoff_det = 1'b1; cts_n = 1'b0; tick(1); xoff_det = 1'b0; tick(1);
    cts_n = 1'b1; tick(3);
    chk("R3 xoff over flow", ident, 8'h10);
    rd_id();
    chk("R8 read clears xoff", ident, 8'h20);
    rd_id();
    chk("R8 read clears flow", ident, 8'h01);
  endtask

  task automatic t_flow_edge();
    rts_n = 1'b0; tick(3);
    chk("R9 falling edge ignored", ident, 8'h01);
    rts_n = 1'b1; tick(3);
    chk("R9 rts rising edge", ident, 8'h20);
    rd_id();
    chk("R9 flow cleared", ident, 8'h01);
  endtask

  task automatic t_enable();
    en_modem = 1'b0;
    modem_chg = 1'b1; tick(1); modem_chg = 1'b0; tick(2);
    chk("R5 disabled modem hidden", ident, 8'h01);
    en_modem = 1'b1; tick(2);
    chk("R5 flag kept until enabled", ident, 8'h00);
    rd_msr = 1'b1; tick(1); rd_msr = 1'b0; tick(2);
    en_rls = 1'b0; lsr_err = 1'b1; tick(2);
    chk("R5 disabled line status hidden", ident, 8'h01);
    lsr_err = 1'b0; en_rls = 1'b1; tick(2);
  endtask

  task automatic t_freeze();
    rd_ident = 1'b1; lsr_err = 1'b1; tick(3);
    chk("R11 held during read", ident, 8'h01);
    rd_ident = 1'b0; tick(1);
    chk("R11 updates after read", ident, 8'h06);
    lsr_err = 1'b0; tick(2);
  endtask

  task automatic t_set_wins();
    thr_set = 1'b1; tick(1); thr_set = 1'b0; tick(2);
    thr_set = 1'b1; rd_ident = 1'b1; tick(1); thr_set = 1'b0; rd_ident = 1'b0; tick(2);
    chk("R12 transmit event beats read", ident, 8'h02);
    thr_wr = 1'b1; tick(1); thr_wr = 1'b0; tick(2);
    modem_chg = 1'b1; rd_msr = 1'b1; tick(1); modem_chg = 1'b0; rd_msr = 1'b0; tick(2);
    chk("R12 modem event beats msr read", ident, 8'h00);
    rd_msr = 1'b1; tick(1); rd_msr = 1'b0; tick(2);
    chk("R12 cleanup", ident, 8'h01);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    en_rls = 1'b1; en_rx = 1'b1; en_thr = 1'b1; en_modem = 1'b1;
    en_pin = 1'b1; en_xoff = 1'b1; en_flow = 1'b1;
    tick(1);
    t_reset();
    t_mirror();
    t_receive();
    t_thr();
    t_modem_pin();
    t_xoff_flow();
    t_flow_edge();
    t_enable();
    t_freeze();
    t_set_wins();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #80000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule